// File: doc/BRIEF.md
# Dual-Halfword Add/Subtract Unit

This unit splits each of two 32-bit operands into a signed upper halfword and a signed lower halfword. It then forms two results at once. The upper halves are added, and the lower half of B is subtracted from the lower half of A. No carry or borrow passes between the two halves. Two option bits shape the result. The first clamps each half to the signed 16-bit range instead of letting it wrap. The second moves the sum into the lower halfword and the difference into the upper halfword.

A caller presents both operands and the option bits together with `in_valid`. One clock later the unit returns the registered 32-bit result, an overflow flag for each operation, a zero flag and a negative flag. The overflow flags belong to the operation (sum or difference), not to a word position. They report overflow whether or not clamping is enabled.

Top module: `dual_half_addsub`

## Requirements
- R1: With both options off, result[31:16] = (A[31:16] + B[31:16]) mod 2^16 and result[15:0] = (A[15:0] - B[15:0]) mod 2^16. Nothing carries or borrows from one half into the other. Example: A = B = 0x65678911 gives 0xCACE0000.
- R2: With `sat_en` = 1, a half whose true signed result is above 32767 becomes 0x7FFF, and a half whose true signed result is below -32768 becomes 0x8000. A half that stays in range is unchanged. Example: A = 0x67694BCD, B = 0x69CF3991 gives 0x7FFF123C.
- R3: With `swap_en` = 1, the sum occupies result[15:0] and the difference occupies result[31:16]. Example: A = B = 0x45678B6B gives 0x00008ACE.
- R4: With both options on, each half is clamped first and the clamped halves are then exchanged. Example: A = 0x043290D6, B = 0x66666777 gives 0x80006A98.
- R5: `add_ovf` is 1 when the unclamped signed sum lies outside -32768..32767. `sub_ovf` is 1 when the unclamped signed difference lies outside that range. Both flags are independent of `sat_en` and `swap_en`.
- R6: `zero_flag` is 1 exactly when the final 32-bit result is 0. `neg_flag` equals bit 31 of the final result.
- R7: Result and flags update on the clock edge at which `in_valid` is 1. `out_valid` is 1 in exactly the cycle after each cycle that has `in_valid` = 1.
- R8: While `in_valid` is 0, `result` and the flags keep their previous values and `out_valid` is 0.
- R9: Synchronous active-high `rst` clears `result`, all flags and `out_valid` to 0.
- R10: With both options off and A = B, result[15:0] is 0 and result[31:16] is 2·A[31:16] mod 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and options are valid this cycle |
| op_a | input | 32 | Operand A (two signed halfwords) |
| op_b | input | 32 | Operand B (two signed halfwords) |
| sat_en | input | 1 | Clamp each half to the signed 16-bit range |
| swap_en | input | 1 | Put the sum low and the difference high |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 32 | Registered packed result |
| add_ovf | output | 1 | Sum half overflowed before clamping |
| sub_ovf | output | 1 | Difference half overflowed before clamping |
| zero_flag | output | 1 | Result is zero |
| neg_flag | output | 1 | Bit 31 of result |

## Verification
The only state is one register stage, so any fault appears at the ports on the cycle after the operation is accepted. A wrong half-placement shows up as a sum and a difference that trade places, which only an operand pair with distinct halves can detect. A wrong clamp polarity shows up only when a half overflows, so the vectors drive overflow in each direction on both halves. A bad enable on the register stage shows up as a result or flag that changes during idle cycles. A bad valid register shows up as an `out_valid` pulse that is missing or doubled.

// File: rtl/dual_half_addsub.sv
module dual_half_addsub #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2*HALF_W-1:0] op_a,
  input  logic [2*HALF_W-1:0] op_b,
  input  logic                sat_en,
  input  logic                swap_en,
  output logic                out_valid,
  output logic [2*HALF_W-1:0] result,
  output logic                add_ovf,
  output logic                sub_ovf,
  output logic                zero_flag,
  output logic                neg_flag
);
  localparam int W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] POS_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] NEG_MIN = {1'b1, {(HALF_W-1){1'b0}}};

  logic [HALF_W:0]   sum_x, dif_x;
  logic              sum_ov, dif_ov;
  logic [HALF_W-1:0] sum_h, dif_h;
  logic [W-1:0]      res_n;

  assign sum_x  = {op_a[W-1], op_a[W-1:HALF_W]} + {op_b[W-1], op_b[W-1:HALF_W]};
  assign dif_x  = {op_a[HALF_W-1], op_a[HALF_W-1:0]} - {op_b[HALF_W-1], op_b[HALF_W-1:0]};
  assign sum_ov = sum_x[HALF_W] ^ sum_x[HALF_W-1];
  assign dif_ov = dif_x[HALF_W] ^ dif_x[HALF_W-1];

  assign sum_h = (sat_en && sum_ov) ? (sum_x[HALF_W] ? NEG_MIN : POS_MAX) : sum_x[HALF_W-1:0];
  assign dif_h = (sat_en && dif_ov) ? (dif_x[HALF_W] ? NEG_MIN : POS_MAX) : dif_x[HALF_W-1:0];
  assign res_n = swap_en ? {dif_h, sum_h} : {sum_h, dif_h};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      add_ovf   <= 1'b0;
      sub_ovf   <= 1'b0;
      zero_flag <= 1'b0;
      neg_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_n;
        add_ovf   <= sum_ov;
        sub_ovf   <= dif_ov;
        zero_flag <= (res_n == '0);
        neg_flag  <= res_n[W-1];
      end
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  // R8
  idle_valid_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(add_ovf) && $stable(sub_ovf)));
  // R6
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (zero_flag == (result == '0)) && (neg_flag == result[W-1]));
  // R10
  same_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_en && !swap_en && op_a == op_b) |=> (result[HALF_W-1:0] == '0 && !sub_ovf));
  // R2
  clamp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en && !swap_en) |=>
      (!add_ovf || result[W-1:HALF_W] == POS_MAX || result[W-1:HALF_W] == NEG_MIN));
endmodule

// File: tb/dual_half_addsub_bench.sv
module dual_half_addsub_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // layout: a[99:68] b[67:36] sat[35] swap[34] exp[33:2] add_ovf[1] sub_ovf[0]
  localparam logic [99:0] VEC [0:NV-1] = '{
    {32'h65678911, 32'h65678911, 1'b0, 1'b0, 32'hCACE0000, 1'b1, 1'b0}, // R1
    {32'hCACE0000, 32'h34845515, 1'b0, 1'b0, 32'hFF52AAEB, 1'b0, 1'b0}, // R1
    {32'h67694BCD, 32'h69CF3991, 1'b1, 1'b0, 32'h7FFF123C, 1'b1, 1'b0}, // R2
    {32'h80000000, 32'h80000000, 1'b1, 1'b0, 32'h80000000, 1'b1, 1'b0}, // R2
    {32'h00017FFF, 32'h00018000, 1'b1, 1'b0, 32'h00027FFF, 1'b0, 1'b1}, // R2
    {32'h00017FFF, 32'h00018000, 1'b0, 1'b0, 32'h0002FFFF, 1'b0, 1'b1}, // R5
    {32'h45678B6B, 32'h45678B6B, 1'b0, 1'b1, 32'h00008ACE, 1'b1, 1'b0}, // R3
    {32'h00010003, 32'h00020001, 1'b0, 1'b1, 32'h00020003, 1'b0, 1'b0}, // R3
    {32'h043290D6, 32'h66666777, 1'b1, 1'b1, 32'h80006A98, 1'b0, 1'b1}, // R4
    {32'h12345699, 32'h1234567F, 1'b1, 1'b0, 32'h2468001A, 1'b0, 1'b0}, // R2
    {32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0}  // R6
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, sat_en = 1'b0, swap_en = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic out_valid, add_ovf, sub_ovf, zero_flag, neg_flag;
  logic [31:0] result;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_half_addsub u_dual_half_addsub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sat_en(sat_en), .swap_en(swap_en), .out_valid(out_valid), .result(result),
    .add_ovf(add_ovf), .sub_ovf(sub_ovf), .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s, input logic w);
    @(negedge clk);
    op_a = a; op_b = b; sat_en = s; swap_en = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 result", result, 32'h0);
    check("R9 flags", {27'd0, out_valid, add_ovf, sub_ovf, zero_flag, neg_flag}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [99:0] v;
      v = VEC[i];
      apply(v[99:68], v[67:36], v[35], v[34]);
      check("R7 out_valid", {31'd0, out_valid}, 32'h1);
      check("R1-R4 vector result", result, v[33:2]);
      check("R5 overflow flags", {30'd0, add_ovf, sub_ovf}, {30'd0, v[1:0]});
      check("R6 zero/neg", {30'd0, zero_flag, neg_flag}, {30'd0, v[33:2] == 32'h0, v[33]});
    end

    // R8 idle: new operands without valid
    @(negedge clk);
    op_a = 32'h7FFF7FFF; op_b = 32'h00010001; sat_en = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R8 out_valid low", {31'd0, out_valid}, 32'h0);
    check("R8 result held", result, 32'h0);
    check("R8 zero flag held", {31'd0, zero_flag}, 32'h1);

    // R7 back-to-back
    @(negedge clk);
    op_a = 32'h00050005; op_b = 32'h00030002; swap_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R7 first of pair", result, 32'h00080003);
    op_a = 32'h00010001; op_b = 32'h00010001;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second of pair", result, 32'h00020000);
    check("R7 valid still high", {31'd0, out_valid}, 32'h1);
    @(negedge clk);
    check("R7 valid drops", {31'd0, out_valid}, 32'h0);

    // R10 same operand random sweep
    for (int k = 0; k < 200; k++) begin
      logic [31:0] x;
      logic [15:0] dbl;
      x = $urandom;
      dbl = x[31:16] + x[31:16];
      apply(x, x, 1'b0, 1'b0);
      check("R10 same operand", result, {dbl, 16'h0000});
    end

    // R9 reset mid-stream with valid asserted
    @(negedge clk);
    op_a = 32'h65678911; op_b = 32'h65678911; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears result", result, 32'h0);
    check("R9 reset clears valid", {31'd0, out_valid}, 32'h0);
    check("R9 reset clears flags", {28'd0, add_ovf, sub_ovf, zero_flag, neg_flag}, 32'h0);
    in_valid = 1'b0; rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule